// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Generator

This block is a clocked supervisor that holds a processor in reset until conditions are safe. It watches a watchdog line that software must keep toggling, and it watches a digital supply-good flag that an external comparator produces. When the watchdog line stops changing for too long, or when the supply-good flag drops, the block drives a reset pulse of fixed minimum length. The reset is given out twice, once active high and once active low.

Both inputs may change at any time with respect to the clock, so each one passes through a two-flop synchronizer. A change on the watchdog line in either direction restarts the watchdog timer. While the supply-good flag is false, reset is held for as long as it stays false. Once the flag is true again, reset is held for one more full pulse length. The timeout and the pulse length are parameters counted in clock cycles. Their defaults give 1.6 s and 200 ms at a 1 MHz clock. The watchdog has no enable and always runs.

Top module: `supervisor_wdt`

## Requirements
- R1: If `wdKick` holds one level for TIMEOUT_CYCLES clock cycles while reset is released, reset is asserted. With the kick held constant, a released period lasts exactly TIMEOUT_CYCLES cycles.
- R2: A rising or a falling transition on `wdKick` clears the watchdog timer. Transitions spaced at most TIMEOUT_CYCLES cycles apart never cause a reset. Transitions spaced TIMEOUT_CYCLES+1 cycles apart do cause one.
- R3: The watchdog timer is cleared whenever reset is asserted. After every release, a full TIMEOUT_CYCLES of inactivity is needed before the next timeout, even when the supply was low for longer than TIMEOUT_CYCLES.
- R4: A reset caused by a watchdog timeout lasts exactly PULSE_CYCLES clock cycles.
- R5: Reset is asserted for as long as `supplyOk` is 0. A change of `supplyOk` reaches the reset outputs on the third rising clock edge after it, because of the two-stage synchronizer. A drop during released operation therefore leaves reset low for three more sampled cycles.
- R6: After `supplyOk` returns to 1, reset stays asserted for PULSE_CYCLES cycles beyond the synchronizer latency. A drop of N cycles taken during released operation gives a pulse of N+PULSE_CYCLES cycles.
- R7: If `supplyOk` drops during a pulse, the pulse length counter restarts. The full PULSE_CYCLES stretch runs again after the supply recovers.
- R8: Transitions on `wdKick` while reset is asserted have no effect. The pulse keeps its length PULSE_CYCLES, and the following released period with a constant kick lasts TIMEOUT_CYCLES.
- R9: `resetLow` is always the inverse of `resetHigh`.
- R10: While `rstN` is 0, `resetHigh`=1 and `resetLow`=0. After `rstN` is released, a full PULSE_CYCLES pulse runs before reset releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset of the block, active low |
| wdKick | input | 1 | Watchdog activity line, asynchronous; either edge kicks |
| supplyOk | input | 1 | Supply-good flag from the external comparator, asynchronous; 1 means good |
| resetLow | output | 1 | Supervisor reset, active low |
| resetHigh | output | 1 | Supervisor reset, active high |

## Verification
The assertions take for granted that TIMEOUT_CYCLES and PULSE_CYCLES are at least 2. They also take for granted that a drop of `supplyOk` lasts at least as long as the synchronizer latency of three cycles, so that the hold state is really entered before recovery. The stimulus changes `wdKick` and `supplyOk` only on falling clock edges. It holds every supply drop for at least five cycles, and it stops toggling the kick a few cycles before a pulse ends, so that no synchronized edge lands in the first released cycle. Each table vector starts from a fresh released period that a short supply drop forces, so that the timer phase is known at the first kick.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_STRETCH = 2'd1,
    ST_RUN     = 2'd2
  } supState_t;

  typedef struct packed {
    logic holdWd;       // keep the watchdog timer at zero
    logic holdStretch;  // keep the pulse counter at zero
  } supStrobe_t;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1600000,
  parameter int PULSE_CYCLES   = 200000,
  parameter int SYNC_STAGES    = 2,
  localparam int WD_W = $clog2(TIMEOUT_CYCLES),
  localparam int PL_W = $clog2(PULSE_CYCLES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wdKick,
  input  logic            supplyOk,
  input  supStrobe_t      strobe,
  output logic            kickEdge,
  output logic            supplyGood,
  output logic            wdExpired,
  output logic            pulseDone,
  output logic [WD_W-1:0] wdCount,
  output logic [PL_W-1:0] pulseCount
);

  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_CYCLES - 1);
  localparam logic [PL_W-1:0] PL_LAST = PL_W'(PULSE_CYCLES - 1);

  logic kickSync;
  logic kickPrev;

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_kickSync (
    .clk(clk), .rstN(rstN), .din(wdKick), .dout(kickSync)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_supplySync (
    .clk(clk), .rstN(rstN), .din(supplyOk), .dout(supplyGood)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) kickPrev <= 1'b0;
    else       kickPrev <= kickSync;
  end

  assign kickEdge = kickSync ^ kickPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        wdCount <= '0;
    else if (strobe.holdWd || kickEdge) wdCount <= '0;
    else if (wdCount != WD_LAST)      wdCount <= wdCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    pulseCount <= '0;
    else if (strobe.holdStretch)  pulseCount <= '0;
    else if (pulseCount != PL_LAST) pulseCount <= pulseCount + 1'b1;
  end

  assign wdExpired = (wdCount == WD_LAST) && !kickEdge;
  assign pulseDone = (pulseCount == PL_LAST);

endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       wdExpired,
  input  logic       pulseDone,
  output supStrobe_t strobe,
  output logic       resetHigh,
  output logic       resetLow
);

  supState_t stateQ;
  supState_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_HOLD:    if (supplyGood) stateD = ST_STRETCH;
      ST_STRETCH: begin
        if (!supplyGood)    stateD = ST_HOLD;
        else if (pulseDone) stateD = ST_RUN;
      end
      ST_RUN: begin
        if (!supplyGood)    stateD = ST_HOLD;
        else if (wdExpired) stateD = ST_STRETCH;
      end
      default:              stateD = ST_STRETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_STRETCH;
    else       stateQ <= stateD;
  end

  assign strobe.holdWd      = (stateQ != ST_RUN);
  assign strobe.holdStretch = (stateQ != ST_STRETCH);
  assign resetHigh          = (stateQ != ST_RUN);
  assign resetLow           = (stateQ == ST_RUN);

  // R10: the block leaves its own reset in the stretch state
  a_r10_por_stretch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (stateQ == ST_STRETCH));

endmodule

// File: rtl/supervisor_wdt.sv
module supervisor_wdt
  import sup_pkg::*;
#(
  parameter int CLK_KHZ        = 1000,
  parameter int TIMEOUT_CYCLES = 1600 * CLK_KHZ,
  parameter int PULSE_CYCLES   = 200 * CLK_KHZ,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdKick,
  input  logic supplyOk,
  output logic resetLow,
  output logic resetHigh
);

  localparam int WD_W = $clog2(TIMEOUT_CYCLES);
  localparam int PL_W = $clog2(PULSE_CYCLES);

  supStrobe_t      strobe;
  logic            kickEdge;
  logic            supplyGood;
  logic            wdExpired;
  logic            pulseDone;
  logic [WD_W-1:0] wdCount;
  logic [PL_W-1:0] pulseCount;

  sup_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .PULSE_CYCLES  (PULSE_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .wdKick(wdKick), .supplyOk(supplyOk),
    .strobe(strobe), .kickEdge(kickEdge), .supplyGood(supplyGood),
    .wdExpired(wdExpired), .pulseDone(pulseDone),
    .wdCount(wdCount), .pulseCount(pulseCount)
  );

  sup_control u_control (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .wdExpired(wdExpired), .pulseDone(pulseDone),
    .strobe(strobe), .resetHigh(resetHigh), .resetLow(resetLow)
  );

  // R1: the timer never runs past its last count
  a_r1_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    wdCount <= WD_W'(TIMEOUT_CYCLES - 1));

  // R3: any cycle in reset leaves the timer at zero
  a_r3_timer_cleared: assert property (@(posedge clk) disable iff (!rstN)
    resetHigh |=> (wdCount == '0));

  // R4: reset only releases after the full pulse count
  a_r4_full_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetHigh) |-> ($past(pulseCount) == PL_W'(PULSE_CYCLES - 1)));

  // R5: a low synchronized supply holds reset
  a_r5_hold_while_low: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> resetHigh);

  // R6: recovery of the supply is followed by asserted reset
  a_r6_stretch_after: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyGood) |=> resetHigh);

  // R7: a sustained low supply clears the pulse counter
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyGood && $past(!supplyGood)) |=> (pulseCount == '0));

endmodule

// File: tb/test_supervisor_wdt.sv
module test_supervisor_wdt;

  localparam int CLK_PERIOD = 10;
  localparam int T = 40;
  localparam int P = 12;
  localparam int N_HOLD = 100;
  localparam int NV = 6;
  // kick spacing (0 = constant), run length, reset expected
  localparam int VECS [0:NV-1][0:2] = '{
    '{5,  300, 0},
    '{17, 300, 0},
    '{40, 300, 0},
    '{41, 300, 1},
    '{60, 300, 1},
    '{0,  300, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdKick = 1'b0;
  logic supplyOk = 1'b1;
  logic resetLow;
  logic resetHigh;

  int total = 0;
  int bad = 0;
  int compBad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supervisor_wdt #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P)) i_supervisor_wdt (
    .clk(clk), .rstN(rstN), .wdKick(wdKick), .supplyOk(supplyOk),
    .resetLow(resetLow), .resetHigh(resetHigh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    if (resetLow !== ~resetHigh) compBad++;
    @(negedge clk);
  endtask

  task automatic countHigh(output int n);
    n = 0;
    while (resetHigh === 1'b1 && n < 2000) begin n++; tick(); end
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (resetHigh === 1'b0 && n < 2000) begin n++; tick(); end
  endtask

  // force a fresh released period with the timer at zero
  task automatic cleanStart();
    int n;
    supplyOk = 1'b0;
    repeat (5) tick();
    supplyOk = 1'b1;
    countHigh(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int lows;
    int highs;
    bit seen;
    repeat (3) @(negedge clk);
    // R10 / R9 reset state
    check(resetHigh === 1'b1, "R10 reset high during rstN", resetHigh, 1);
    check(resetLow === 1'b0, "R9 reset low during rstN", resetLow, 0);
    rstN = 1'b1;
    countHigh(n);
    check(n == P, "R10 power-on pulse length", n, P);
    countLow(n);
    check(n == T, "R1 timeout with constant kick", n, T);
    countHigh(n);
    check(n == P, "R4 watchdog pulse length", n, P);
    countLow(n);
    check(n == T, "R3 timer cleared by reset", n, T);

    // R2 / R1 table of kick spacings
    for (int v = 0; v < NV; v++) begin
      cleanStart();
      seen = 1'b0;
      for (int i = 0; i < VECS[v][1]; i++) begin
        if (VECS[v][0] > 0 && (i % VECS[v][0]) == 0) wdKick = ~wdKick;
        if (resetHigh === 1'b1) seen = 1'b1;
        tick();
      end
      check(seen == VECS[v][2], $sformatf("R2 kick spacing %0d", VECS[v][0]),
            seen, VECS[v][2]);
    end

    // R5 / R6 supply drop during released operation
    cleanStart();
    supplyOk = 1'b0;
    lows = 0;
    highs = 0;
    for (int i = 0; i < N_HOLD; i++) begin
      if (resetHigh === 1'b1) highs++; else lows++;
      tick();
    end
    supplyOk = 1'b1;
    countHigh(n);
    highs += n;
    check(lows == 3, "R5 synchronizer latency of supply drop", lows, 3);
    check(highs == N_HOLD + P, "R6 hold plus stretch length", highs, N_HOLD + P);
    countLow(n);
    check(n == T, "R3 timer fresh after long supply hold", n, T);

    // R7 supply drop inside a pulse restarts the stretch
    repeat (P / 2) tick();
    supplyOk = 1'b0;
    repeat (6) tick();
    supplyOk = 1'b1;
    countHigh(n);
    check(n == P + 3, "R7 stretch restarted after recovery", n, P + 3);
    countLow(n);
    check(n == T, "R1 timeout after restarted pulse", n, T);

    // R8 kicks during reset are ignored
    highs = 0;
    for (int i = 0; i < P - 4; i++) begin
      if ((i % 2) == 0) wdKick = ~wdKick;
      if (resetHigh === 1'b1) highs++;
      tick();
    end
    countHigh(n);
    highs += n;
    check(highs == P, "R8 pulse length with kicks in reset", highs, P);
    countLow(n);
    check(n == T, "R8 released period after kicks in reset", n, T);

    check(compBad == 0, "R9 outputs complementary", compBad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule